// File: doc/BRIEF.md
# Six-Step Commutation Output Sequencer

This block sits between three per-phase PWM generators and the six gate-drive pins of a three-phase brushless motor bridge, one high-side and one low-side pin per phase. A 3-bit sector code chooses, for every phase, one of three pin modes. In the first, the high pin carries that phase's PWM and the low pin is held at the override level. In the second, the low pin carries the PWM and the high pin is held. In the third, both pins are held. In each valid sector exactly one high-side switch and one low-side switch, on two different phases, are modulated. All other pins stay at the override level, which is logic 0.

Sector requests arrive on a valid/ready port and are kept in a shadow register. The block never stalls this port: ready is held high, and a request written before the next PWM start-of-cycle replaces the one already pending. The pending code moves into the applied register only on a clock edge where the start-of-cycle pulse is high, so the pin pattern changes only at a PWM cycle boundary. Codes 0 and 7 are not sectors, and applying one holds all six pins low. After reset the applied code is 0, so every pin is held low until a valid sector has been applied at a boundary.

Top module: `commutation_sequencer`

## Requirements
- R1: After reset, gate_hi and gate_lo are 3'b000 whatever pwm_in does, until a start-of-cycle pulse has applied a valid sector.
- R2: Sector codes 1 to 6 select this pattern, where bit p of each bus is phase p, H means the high pin is modulated and L means the low pin is modulated:
  - 1: phase 0 H, phase 2 L
  - 2: phase 1 H, phase 2 L
  - 3: phase 1 H, phase 0 L
  - 4: phase 2 H, phase 0 L
  - 5: phase 2 H, phase 1 L
  - 6: phase 0 H, phase 1 L
- R3: A modulated pin equals pwm_in of its own phase in the same cycle. Every pin that is not modulated is 0.
- R4: In any cycle, at most one bit of gate_hi follows PWM and at most one bit of gate_lo follows PWM. No phase has both of its pins high at once.
- R5: A request changes no output until the clock edge that samples soc high. The new pattern is visible from that edge on.
- R6: A newer request accepted before the boundary replaces the pending code. At the boundary only the latest code is applied.
- R7: An applied code of 0 or 7 holds all six outputs at 0.
- R8: sec_ready is always 1, and every cycle with sec_valid high is an accepted request.
- R9: A request accepted on the same edge as a start-of-cycle pulse is not applied at that edge. It is applied at the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 3 | PWM waveform of each phase, bit p is phase p |
| soc | input | 1 | One-cycle pulse marking the start of a PWM cycle |
| sec_valid | input | 1 | Sector request valid |
| sec_ready | output | 1 | Sector request ready (always 1) |
| sec_code | input | 3 | Requested sector code |
| gate_hi | output | 3 | High-side gate drives, bit p is phase p |
| gate_lo | output | 3 | Low-side gate drives, bit p is phase p |

## Verification
The assertions assume that reset is held low across the first clock edge, and that soc is a clean single-cycle pulse sampled on the same clock as the request port. The bench drives every input on the falling edge, and it raises soc for exactly one cycle at a time. The boundary assertion and the reset assertion watch the applied code and the first boundary. These checks are only meaningful if pwm_in, sec_code and soc are never left unknown after reset, so the bench gives every input a defined value from time zero.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int NUM_PH = 3;
  localparam int SEC_W  = 3;
  localparam logic OVR_LEVEL = 1'b0;

  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_HI   = 2'd1,
    PM_LO   = 2'd2
  } phase_mode_t;

  // Arithmetic sector decode: the high-side phase advances on odd steps,
  // the low-side phase advances on even steps.
  function automatic phase_mode_t mode_of(input logic [SEC_W-1:0] sec, input int ph);
    int k;
    int hp;
    int lp;
    if (sec == '0 || sec > SEC_W'(2*NUM_PH)) return PM_HOLD;
    k  = int'(sec) - 1;
    hp = ((k + 1) / 2) % NUM_PH;
    lp = ((k / 2) + 2) % NUM_PH;
    if (ph == hp) return PM_HI;
    if (ph == lp) return PM_LO;
    return PM_HOLD;
  endfunction
endpackage

// File: rtl/cmt_sector_shadow.sv
module cmt_sector_shadow
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SEC_W-1:0] in_code,
  output logic             in_ready,
  output logic [SEC_W-1:0] pend_code
);
  // Never back-pressures: the latest write always wins.
  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_code <= '0;
    else if (in_valid && in_ready) pend_code <= in_code;
  end
endmodule

// File: rtl/cmt_sector_apply.sv
module cmt_sector_apply
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc,
  input  logic [SEC_W-1:0] pend_code,
  output logic [SEC_W-1:0] applied_code
);
  always_ff @(posedge clk) begin
    if (!rst_n)   applied_code <= '0;
    else if (soc) applied_code <= pend_code;
  end
endmodule

// File: rtl/cmt_phase_map.sv
module cmt_phase_map
  import cmt_pkg::*;
(
  input  logic [SEC_W-1:0]  applied_code,
  output logic [NUM_PH-1:0] hi_en,
  output logic [NUM_PH-1:0] lo_en
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    phase_mode_t mode;
    always_comb begin
      mode     = mode_of(applied_code, p);
      hi_en[p] = (mode == PM_HI);
      lo_en[p] = (mode == PM_LO);
    end
  end
endmodule

// File: rtl/cmt_pin_drive.sv
module cmt_pin_drive
  import cmt_pkg::*;
(
  input  logic pwm,
  input  logic hi_en,
  input  logic lo_en,
  output logic gate_hi,
  output logic gate_lo
);
  always_comb begin
    gate_hi = hi_en ? pwm : OVR_LEVEL;
    gate_lo = lo_en ? pwm : OVR_LEVEL;
  end
endmodule

// File: rtl/commutation_sequencer.sv
module commutation_sequencer
  import cmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] pwm_in,
  input  logic              soc,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic [SEC_W-1:0]  sec_code,
  output logic [NUM_PH-1:0] gate_hi,
  output logic [NUM_PH-1:0] gate_lo
);
  logic [SEC_W-1:0]  pend_code;
  logic [SEC_W-1:0]  applied_code;
  logic [NUM_PH-1:0] hi_en;
  logic [NUM_PH-1:0] lo_en;

  cmt_sector_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .in_valid(sec_valid), .in_code(sec_code),
    .in_ready(sec_ready), .pend_code(pend_code)
  );

  cmt_sector_apply u_apply (
    .clk(clk), .rst_n(rst_n), .soc(soc), .pend_code(pend_code),
    .applied_code(applied_code)
  );

  cmt_phase_map u_map (
    .applied_code(applied_code), .hi_en(hi_en), .lo_en(lo_en)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_drv
    cmt_pin_drive u_drv (
      .pwm(pwm_in[p]), .hi_en(hi_en[p]), .lo_en(lo_en[p]),
      .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
    );
  end
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker
  import cmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soc,
  input logic [NUM_PH-1:0] pwm,
  input logic [NUM_PH-1:0] gate_hi,
  input logic [NUM_PH-1:0] gate_lo,
  input logic              sec_ready,
  input logic [SEC_W-1:0]  applied,
  input logic [NUM_PH-1:0] hi_en,
  input logic [NUM_PH-1:0] lo_en
);
  logic seen_soc;
  always_ff @(posedge clk) begin
    if (!rst_n)   seen_soc <= 1'b0;
    else if (soc) seen_soc <= 1'b1;
  end

  a_r1_low_before_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_soc |-> (gate_hi == '0 && gate_lo == '0));

  a_r3_hi_follows: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi == (pwm & hi_en));

  a_r3_lo_follows: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo == (pwm & lo_en));

  a_r4_one_each: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_en) && $onehot0(lo_en) && ($countones(hi_en) == $countones(lo_en)));

  a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !soc |=> $stable(applied));

  a_r7_invalid_low: assert property (@(posedge clk) disable iff (!rst_n)
    (applied == '0 || applied == '1) |-> (hi_en == '0 && lo_en == '0));

  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ready);
endmodule

bind commutation_sequencer cmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soc(soc), .pwm(pwm_in),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .sec_ready(sec_ready),
  .applied(applied_code), .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/commutation_sequencer_tb.sv
module commutation_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pwm_in = 3'b000;
  logic       soc = 1'b0;
  logic       sec_valid = 1'b0;
  logic [2:0] sec_code = 3'd0;
  logic       sec_ready;
  logic [2:0] gate_hi, gate_lo;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  commutation_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .soc(soc),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_code(sec_code),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Expected pins from the sector table of R2 and the rule of R3/R7.
  function automatic void expect_pins(input int s, input logic [2:0] pw,
                                      output logic [2:0] eh, output logic [2:0] el);
    int hp, lp;
    case (s)
      1: begin hp = 0; lp = 2; end
      2: begin hp = 1; lp = 2; end
      3: begin hp = 1; lp = 0; end
      4: begin hp = 2; lp = 0; end
      5: begin hp = 2; lp = 1; end
      6: begin hp = 0; lp = 1; end
      default: begin hp = -1; lp = -1; end
    endcase
    eh = 3'b000; el = 3'b000;
    if (hp >= 0) begin
      eh[hp] = pw[hp];
      el[lp] = pw[lp];
    end
  endfunction

  task automatic check_pins(input string tag, input int s, input logic [2:0] pw);
    logic [2:0] eh, el;
    pwm_in = pw;
    #1;
    expect_pins(s, pw, eh, el);
    n_checks++;
    if (gate_hi !== eh || gate_lo !== el) begin
      n_errors++;
      $display("FAIL %s: sector %0d pwm=%b actual hi=%b lo=%b expected hi=%b lo=%b",
               tag, s, pw, gate_hi, gate_lo, eh, el);
    end
  endtask

  task automatic check_ready(input string tag);
    n_checks++;
    if (sec_ready !== 1'b1) begin
      n_errors++;
      $display("FAIL %s: actual ready=%b expected 1", tag, sec_ready);
    end
  endtask

  task automatic send_req(input int code);
    @(negedge clk);
    sec_valid = 1'b1; sec_code = 3'(code);
    @(negedge clk);
    sec_valid = 1'b0;
  endtask

  task automatic pulse_soc();
    @(negedge clk);
    soc = 1'b1;
    @(negedge clk);
    soc = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, and still low with a request but no boundary
    check_pins("R1 reset", 0, 3'b111);
    send_req(3);
    check_ready("R8 after request");
    check_pins("R1 no boundary yet", 0, 3'b111);
    check_pins("R1 no boundary yet", 0, 3'b101);

    // R2/R3/R4/R7 sweep: every code, every PWM pattern
    for (int i = 1; i <= 8; i++) begin
      int s;
      s = i % 8;
      send_req(s);
      pulse_soc();
      for (int pw = 0; pw < 8; pw++) begin
        if (s >= 1 && s <= 6) check_pins("R2 R3 R4 sweep", s, 3'(pw));
        else                  check_pins("R7 invalid code", 0, 3'(pw));
      end
    end

    // R5: request takes no effect until the boundary
    send_req(2);
    pulse_soc();
    send_req(5);
    repeat (3) @(negedge clk);
    check_pins("R5 held until boundary", 2, 3'b111);
    check_pins("R5 held until boundary", 2, 3'b010);
    pulse_soc();
    check_pins("R5 applied at boundary", 5, 3'b111);

    // R6: newer request replaces the pending one
    send_req(4);
    send_req(6);
    check_ready("R8 back to back");
    pulse_soc();
    check_pins("R6 latest wins", 6, 3'b111);
    check_pins("R6 latest wins", 6, 3'b011);

    // R9: request on the same edge as soc waits a cycle
    @(negedge clk);
    sec_valid = 1'b1; sec_code = 3'd1; soc = 1'b1;
    @(negedge clk);
    sec_valid = 1'b0; soc = 1'b0;
    check_pins("R9 not applied same edge", 6, 3'b111);
    pulse_soc();
    check_pins("R9 applied next boundary", 1, 3'b111);

    // R7 after a valid sector: code 7 forces all low
    send_req(7);
    pulse_soc();
    check_pins("R7 code 7 after valid", 0, 3'b111);
    check_ready("R8 end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule